// File: doc/BRIEF.md
# Transaction commit and squash sequencer

This controller sits beside a speculative data cache and drives the end of each transaction. While a transaction runs, every store to a word whose modified flag is still clear has its address appended to a small address log. Stores to words already flagged are not logged again. When the processor ends the transaction, the sequencer takes a commit token from an external arbiter through a request/grant pair. It pulses a gang-clear of the read flags, then walks the log in order. For each entry it reads the log and then the cache word, and offers an address/data packet on a valid/ready output. It finishes by pulsing a gang-clear of the modified flags, emptying the log, dropping the token request and giving a done pulse.

A violation reported by the cache side starts a squash instead. The same log walk emits one line invalidation per entry, then the read flags are gang-cleared, and finally the log is emptied while a checkpoint restore and a done pulse are given together. Once the token has been granted a violation is ignored, because the committing transaction cannot be squashed. If a new store would have to be logged while the log is full, the store is held off. The sequencer obtains the token and commits what has been logged, then runs non-speculatively: every further store, the held one first, passes straight to the packet output until the transaction ends. The token is then released.

Top module: `spec_commit_seq`

## Requirements
- R1: A store accepted with st_dirty_i low is logged. A store with st_dirty_i high is accepted but not logged, so it produces no packet or invalidation later.
- R2: end_i in idle raises tok_req_o. No flag clear, cache read or packet occurs before tok_gnt_i is seen high.
- R3: After the grant, a commit gives exactly this sequence: one clr_rd_o pulse, then per log entry in store order one cache read and one packet, then one clr_mod_o pulse, then a done_o pulse with tok_req_o low.
- R4: Each cache read is a one-cycle rd_en_o with rd_addr_o equal to the entry. rd_data_i, valid in the cycle after the read, becomes pkt_data_o for that entry.
- R5: While pkt_ready_i is low, the pending packet stays valid with stable address and data. No entry is skipped or sent twice.
- R6: viol_i in idle starts a squash. It gives one inv_o per log entry in store order, then a clr_rd_o pulse, then restore_o and done_o together, and no packet.
- R7: viol_i arriving after the grant, during the commit walk, has no effect: the commit sequence completes unchanged and no restore_o occurs.
- R8: A clean store arriving while the log holds DEPTH entries is stalled. The log is committed under the token, and then that store and every later one appear directly as packets with their own address and data. On end_i the block gives done_o and drops tok_req_o.
- R9: A commit or squash with an empty log still gives the clear pulses and done_o, without packets, reads or invalidations.
- R10: After reset all pulse outputs, tok_req_o and pkt_valid_o are low.
- R11: viol_i while the token request waits for its grant abandons the commit. tok_req_o drops and a squash runs instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Processor store valid |
| st_addr_i | input | ADDR_W | Store word address |
| st_data_i | input | DATA_W | Store data (used in non-speculative mode) |
| st_dirty_i | input | 1 | Modified flag of the word is already set |
| st_stall_o | output | 1 | Store not accepted this cycle |
| end_i | input | 1 | Transaction end, start commit |
| viol_i | input | 1 | Violation from the cache side, start squash |
| tok_req_o | output | 1 | Commit token request |
| tok_gnt_i | input | 1 | Commit token grant |
| clr_rd_o | output | 1 | Gang-clear of read flags |
| clr_mod_o | output | 1 | Gang-clear of modified flags |
| rd_en_o | output | 1 | Cache word read strobe |
| rd_addr_o | output | ADDR_W | Cache read address |
| rd_data_i | input | DATA_W | Cache read data, one cycle after the strobe |
| pkt_valid_o | output | 1 | Commit packet valid |
| pkt_addr_o | output | ADDR_W | Commit packet address |
| pkt_data_o | output | DATA_W | Commit packet data |
| pkt_ready_i | input | 1 | Commit packet accepted |
| inv_o | output | 1 | Line invalidate strobe during squash |
| inv_addr_o | output | ADDR_W | Address to invalidate |
| restore_o | output | 1 | Restore register checkpoint |
| done_o | output | 1 | Commit or squash finished |

## Verification
A wrong log count or walk index shows at the ports as a missing, repeated or reordered packet or invalidation within the walk. It appears at most a few cycles after the clear pulse. A sequencing fault shows as a clear pulse, cache read or packet before the grant, or after the done pulse, or as a restore during a commit. Each of these is visible in the same transaction. A fault in overflow handling shows as the held store never appearing as a packet, or as the token staying requested after the transaction has ended.

// File: rtl/spec_seq_pkg.sv
package spec_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_CLR_RD, S_FRD, S_CRD, S_CAP, S_SEND, S_CLR_MOD,
    S_NSPEC, S_REL, S_SQ_INV, S_SQ_CLR, S_SQ_END
  } seq_state_e;
endpackage

// File: rtl/spec_addr_log.sv
module spec_addr_log #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              step_i,
  input  logic              clear_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              last_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_i && cnt_q == CW'(g)) mem_q[g] <= push_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      if (push_i) cnt_q <= cnt_q + CW'(1);
      if (step_i) idx_q <= idx_q + IW'(1);
    end
  end

  assign head_addr_o = mem_q[idx_q];
  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign last_o      = ((CW'(idx_q) + CW'(1)) == cnt_q);

  p_no_push_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_step_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !empty_o);
endmodule

// File: rtl/spec_seq_ctrl.sv
module spec_seq_ctrl
  import spec_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              st_dirty_i,
  output logic              st_stall_o,
  input  logic              end_i,
  input  logic              viol_i,
  output logic              tok_req_o,
  input  logic              tok_gnt_i,
  output logic              clr_rd_o,
  output logic              clr_mod_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              pkt_valid_o,
  output logic [ADDR_W-1:0] pkt_addr_o,
  output logic [DATA_W-1:0] pkt_data_o,
  input  logic              pkt_ready_i,
  output logic              inv_o,
  output logic [ADDR_W-1:0] inv_addr_o,
  output logic              restore_o,
  output logic              done_o,
  // address log
  output logic              push_o,
  output logic              step_o,
  output logic              clear_o,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic              empty_i,
  input  logic              full_i,
  input  logic              last_i
);
  seq_state_e        state_q, state_d;
  logic              ovf_q, ovf_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dat_q;
  logic              st_acc, ovf_hit;

  assign ovf_hit = st_valid_i && !st_dirty_i && full_i;

  always_comb begin
    st_acc = 1'b0;
    if (state_q == S_IDLE) st_acc = st_valid_i && !viol_i && !end_i && !ovf_hit;
    else if (state_q == S_NSPEC) st_acc = st_valid_i && pkt_ready_i && !end_i;
  end
  assign st_stall_o = st_valid_i && !st_acc;
  assign push_o     = (state_q == S_IDLE) && st_acc && !st_dirty_i;

  always_comb begin
    state_d = state_q;
    ovf_d   = ovf_q;
    step_o  = 1'b0;
    clear_o = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (viol_i) state_d = empty_i ? S_SQ_CLR : S_SQ_INV;
        else if (end_i) state_d = S_REQ;
        else if (ovf_hit) begin
          state_d = S_REQ;
          ovf_d   = 1'b1;
        end
      end
      S_REQ: begin
        if (viol_i) begin  // not yet holder: squash wins
          state_d = empty_i ? S_SQ_CLR : S_SQ_INV;
          ovf_d   = 1'b0;
        end else if (tok_gnt_i) state_d = S_CLR_RD;
      end
      S_CLR_RD:  state_d = empty_i ? S_CLR_MOD : S_FRD;
      S_FRD:     state_d = S_CRD;
      S_CRD:     state_d = S_CAP;
      S_CAP:     state_d = S_SEND;
      S_SEND: begin
        if (pkt_ready_i) begin
          step_o  = 1'b1;
          state_d = last_i ? S_CLR_MOD : S_FRD;
        end
      end
      S_CLR_MOD: begin
        clear_o = 1'b1;
        state_d = ovf_q ? S_NSPEC : S_REL;
      end
      S_NSPEC: if (end_i) state_d = S_REL;
      S_REL: begin
        state_d = S_IDLE;
        ovf_d   = 1'b0;
      end
      S_SQ_INV: begin
        step_o = 1'b1;
        if (last_i) state_d = S_SQ_CLR;
      end
      S_SQ_CLR:  state_d = S_SQ_END;
      S_SQ_END: begin
        clear_o = 1'b1;
        state_d = S_IDLE;
      end
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ovf_q   <= 1'b0;
      addr_q  <= '0;
      dat_q   <= '0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
      if (state_q == S_FRD) addr_q <= head_addr_i;
      if (state_q == S_CAP) dat_q  <= rd_data_i;
    end
  end

  assign tok_req_o = (state_q == S_REQ) || (state_q == S_CLR_RD) || (state_q == S_FRD) ||
                     (state_q == S_CRD) || (state_q == S_CAP) || (state_q == S_SEND) ||
                     (state_q == S_CLR_MOD) || (state_q == S_NSPEC);
  assign clr_rd_o    = (state_q == S_CLR_RD) || (state_q == S_SQ_CLR);
  assign clr_mod_o   = (state_q == S_CLR_MOD);
  assign rd_en_o     = (state_q == S_CRD);
  assign rd_addr_o   = addr_q;
  assign pkt_valid_o = (state_q == S_SEND) || ((state_q == S_NSPEC) && st_valid_i && !end_i);
  assign pkt_addr_o  = (state_q == S_SEND) ? addr_q : st_addr_i;
  assign pkt_data_o  = (state_q == S_SEND) ? dat_q : st_data_i;
  assign inv_o       = (state_q == S_SQ_INV);
  assign inv_addr_o  = head_addr_i;
  assign restore_o   = (state_q == S_SQ_END);
  assign done_o      = (state_q == S_SQ_END) || (state_q == S_REL);

  p_pkt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SEND && !pkt_ready_i) |=>
      (pkt_valid_o && $stable(pkt_addr_o) && $stable(pkt_data_o)));
  p_pkt_under_token_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> tok_req_o);
  p_restore_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (done_o && !tok_req_o && !pkt_valid_o));
  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == S_IDLE));
  p_rd_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  p_viol_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_req_o && state_q != S_REQ) |=> (state_q != S_SQ_INV && state_q != S_SQ_CLR));
  p_wait_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_REQ && !tok_gnt_i) |=> (state_q == S_REQ || state_q == S_SQ_INV ||
                                          state_q == S_SQ_CLR));
endmodule

// File: rtl/spec_commit_seq.sv
module spec_commit_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              st_dirty_i,
  output logic              st_stall_o,
  input  logic              end_i,
  input  logic              viol_i,
  output logic              tok_req_o,
  input  logic              tok_gnt_i,
  output logic              clr_rd_o,
  output logic              clr_mod_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              pkt_valid_o,
  output logic [ADDR_W-1:0] pkt_addr_o,
  output logic [DATA_W-1:0] pkt_data_o,
  input  logic              pkt_ready_i,
  output logic              inv_o,
  output logic [ADDR_W-1:0] inv_addr_o,
  output logic              restore_o,
  output logic              done_o
);
  logic              push, step, clear, empty, full, last;
  logic [ADDR_W-1:0] head_addr;

  spec_addr_log #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_log (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(st_addr_i), .step_i(step), .clear_i(clear),
    .head_addr_o(head_addr), .empty_o(empty), .full_o(full), .last_o(last)
  );

  spec_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .st_valid_i, .st_addr_i, .st_data_i, .st_dirty_i, .st_stall_o,
    .end_i, .viol_i, .tok_req_o, .tok_gnt_i,
    .clr_rd_o, .clr_mod_o, .rd_en_o, .rd_addr_o, .rd_data_i,
    .pkt_valid_o, .pkt_addr_o, .pkt_data_o, .pkt_ready_i,
    .inv_o, .inv_addr_o, .restore_o, .done_o,
    .push_o(push), .step_o(step), .clear_o(clear),
    .head_addr_i(head_addr), .empty_i(empty), .full_i(full), .last_i(last)
  );
endmodule

// File: tb/spec_commit_seq_bench.sv
module spec_commit_seq_bench;
  localparam int PERIOD = 10;
  localparam int AW = 8, DW = 16, DEPTH = 4;
  localparam int MAXEV = 64;
  // event codes
  localparam int E_CLR_RD = 1, E_PKT = 2, E_CLR_MOD = 3, E_DONE = 4,
                 E_INV = 5, E_RESTORE = 6, E_RD = 7;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, st_dirty = 0, end_p = 0, viol = 0, gnt = 0, ready = 1;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0, rd_data = '0;
  logic st_stall, tok_req, clr_rd, clr_mod, rd_en, pkt_valid, inv, restore, done;
  logic [AW-1:0] rd_addr, pkt_addr, inv_addr;
  logic [DW-1:0] pkt_data;

  spec_commit_seq #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_spec_commit_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_dirty_i(st_dirty),
    .st_stall_o(st_stall), .end_i(end_p), .viol_i(viol),
    .tok_req_o(tok_req), .tok_gnt_i(gnt),
    .clr_rd_o(clr_rd), .clr_mod_o(clr_mod), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .pkt_valid_o(pkt_valid), .pkt_addr_o(pkt_addr),
    .pkt_data_o(pkt_data), .pkt_ready_i(ready), .inv_o(inv), .inv_addr_o(inv_addr),
    .restore_o(restore), .done_o(done)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit gnt_en = 1, ready_mode = 0;
  int rc = 0;

  int ev_c [MAXEV]; int ev_a [MAXEV]; int ev_d [MAXEV]; int nev = 0;
  int ex_c [MAXEV]; int ex_a [MAXEV]; int ex_d [MAXEV]; int nex = 0;
  bit seen_done = 0;

  function automatic logic [DW-1:0] wdata(input logic [AW-1:0] a);
    return {a ^ 8'h5A, a + 8'd7};
  endfunction

  // cache model: registered read
  always @(posedge clk) if (rd_en) rd_data <= wdata(rd_addr);

  // grant and ready drivers, away from edges
  initial forever begin
    @(posedge clk); #2;
    gnt = tok_req & gnt_en;
    rc++;
    ready = ready_mode ? (rc % 3 != 0) : 1'b1;
  end

  task automatic log_ev(input int c, input int a, input int d);
    if (nev < MAXEV) begin ev_c[nev] = c; ev_a[nev] = a; ev_d[nev] = d; end
    nev++;
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (clr_rd) log_ev(E_CLR_RD, 0, 0);
      if (rd_en) log_ev(E_RD, rd_addr, 0);
      if (pkt_valid && ready) log_ev(E_PKT, pkt_addr, pkt_data);
      if (clr_mod) log_ev(E_CLR_MOD, 0, 0);
      if (inv) log_ev(E_INV, inv_addr, 0);
      if (restore) log_ev(E_RESTORE, 0, 0);
      if (done) begin log_ev(E_DONE, 0, 0); seen_done = 1; end
    end
  end

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic exp_add(input int c, input int a, input int d);
    ex_c[nex] = c; ex_a[nex] = a; ex_d[nex] = d; nex++;
  endtask

  task automatic clear_log();
    nev = 0; nex = 0; seen_done = 0;
  endtask

  task automatic cmp_seq(input string rq);
    check(nev == nex, rq, "event count", nev, nex);
    for (int i = 0; i < nex && i < nev && i < MAXEV; i++) begin
      check(ev_c[i] == ex_c[i], rq, $sformatf("event %0d code", i), ev_c[i], ex_c[i]);
      check(ev_a[i] == ex_a[i], rq, $sformatf("event %0d addr", i), ev_a[i], ex_a[i]);
      check(ev_d[i] == ex_d[i], rq, $sformatf("event %0d data", i), ev_d[i], ex_d[i]);
    end
  endtask

  task automatic do_store(input logic [AW-1:0] a, input bit dirty);
    @(posedge clk); #1;
    st_valid = 1; st_addr = a; st_data = wdata(a); st_dirty = dirty;
    #2;
    while (st_stall) begin @(posedge clk); #3; end
    @(posedge clk); #1;
    st_valid = 0; st_dirty = 0;
  endtask

  task automatic pulse_end();
    @(posedge clk); #1 end_p = 1;
    @(posedge clk); #1 end_p = 0;
  endtask

  task automatic pulse_viol();
    @(posedge clk); #1 viol = 1;
    @(posedge clk); #1 viol = 0;
  endtask

  task automatic wait_done(input string rq);
    int t = 0;
    while (!seen_done && t < 300) begin @(posedge clk); t++; end
    repeat (3) @(posedge clk);
    #4;
    check(seen_done, rq, "done seen", seen_done, 1);
    check(!tok_req, rq, "token released", tok_req, 0);
  endtask

  function automatic logic [AW-1:0] addr_of(input int run, input int k);
    return AW'(8'h11 * (run + 1) + k * 5);
  endfunction

  task automatic add_commit_exp(input int run, input int n);
    exp_add(E_CLR_RD, 0, 0);
    for (int k = 0; k < n; k++) begin
      exp_add(E_RD, addr_of(run, k), 0);
      exp_add(E_PKT, addr_of(run, k), wdata(addr_of(run, k)));
    end
    exp_add(E_CLR_MOD, 0, 0);
  endtask

  // watchdog
  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int run = 0;
    repeat (3) @(posedge clk);
    #4;
    // R10 reset state
    check(!tok_req && !pkt_valid && !clr_rd && !clr_mod && !rd_en && !inv && !restore && !done,
          "R10", "outputs in reset", {tok_req, pkt_valid, done}, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);
    #4;
    check(!tok_req && !pkt_valid && !done, "R10", "outputs after reset", {tok_req, pkt_valid, done}, 0);

    // commit sweep: R1 R3 R4 R5 R9
    for (int rm = 0; rm < 2; rm++) begin
      for (int n = 0; n <= DEPTH; n++) begin
        ready_mode = bit'(rm);
        clear_log();
        for (int k = 0; k < n; k++) do_store(addr_of(run, k), 0);
        if (n > 0) do_store(addr_of(run, 0), 1);  // R1: flagged word not logged again
        if (n == 2 && rm == 0) begin
          // R2: hold grant back and look for early activity
          gnt_en = 0;
          pulse_end();
          repeat (6) @(posedge clk);
          #4;
          check(tok_req, "R2", "request while waiting", tok_req, 1);
          check(nev == 0, "R2", "events before grant", nev, 0);
          gnt_en = 1;
        end else pulse_end();
        wait_done(n == 0 ? "R9" : "R3");
        add_commit_exp(run, n);
        exp_add(E_DONE, 0, 0);
        cmp_seq(rm ? "R5" : (n == 0 ? "R9" : "R4"));
        run++;
      end
    end
    ready_mode = 0;

    // squash sweep: R6 R9
    for (int n = 0; n <= DEPTH; n++) begin
      clear_log();
      for (int k = 0; k < n; k++) do_store(addr_of(run, k), 0);
      if (n > 1) do_store(addr_of(run, 1), 1);
      pulse_viol();
      wait_done("R6");
      for (int k = 0; k < n; k++) exp_add(E_INV, addr_of(run, k), 0);
      exp_add(E_CLR_RD, 0, 0);
      exp_add(E_RESTORE, 0, 0);
      exp_add(E_DONE, 0, 0);
      cmp_seq(n == 0 ? "R9" : "R6");
      run++;
    end

    // R7: violation during the commit walk is ignored
    clear_log();
    ready_mode = 1;
    for (int k = 0; k < 3; k++) do_store(addr_of(run, k), 0);
    pulse_end();
    repeat (6) @(posedge clk);
    pulse_viol();
    wait_done("R7");
    add_commit_exp(run, 3);
    exp_add(E_DONE, 0, 0);
    cmp_seq("R7");
    ready_mode = 0;
    run++;

    // R11: violation while waiting for grant
    clear_log();
    for (int k = 0; k < 2; k++) do_store(addr_of(run, k), 0);
    gnt_en = 0;
    pulse_end();
    repeat (3) @(posedge clk);
    pulse_viol();
    wait_done("R11");
    gnt_en = 1;
    for (int k = 0; k < 2; k++) exp_add(E_INV, addr_of(run, k), 0);
    exp_add(E_CLR_RD, 0, 0);
    exp_add(E_RESTORE, 0, 0);
    exp_add(E_DONE, 0, 0);
    cmp_seq("R11");
    run++;

    // R8: overflow fallback
    clear_log();
    for (int k = 0; k < DEPTH; k++) do_store(addr_of(run, k), 0);
    for (int k = DEPTH; k < DEPTH + 3; k++) do_store(addr_of(run, k), 0);
    #4;
    check(tok_req, "R8", "token held in fallback", tok_req, 1);
    pulse_end();
    wait_done("R8");
    add_commit_exp(run, DEPTH);
    for (int k = DEPTH; k < DEPTH + 3; k++)
      exp_add(E_PKT, addr_of(run, k), wdata(addr_of(run, k)));
    exp_add(E_DONE, 0, 0);
    cmp_seq("R8");
    run++;

    // after fallback, speculation resumes normally (R1)
    clear_log();
    do_store(addr_of(run, 0), 0);
    pulse_end();
    wait_done("R1");
    add_commit_exp(run, 1);
    exp_add(E_DONE, 0, 0);
    cmp_seq("R1");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule